// File: doc/BRIEF.md
# I/Q Stream Frame Capture Buffer

This block sits between a radio sample stream and a neural-network classifier. Each stream beat is one 32-bit word holding an in-phase and a quadrature value. The block splits every word and stores the two halves in two separate on-chip planes, each organised as 32 rows by 32 columns. The planes are filled in row-major order. When the 1024th sample of a frame has been written, the block raises a frame-ready flag. It then refuses further samples until the consumer acknowledges the frame, so a frame cannot be overwritten while it is being read.

The consumer reads either plane through an independent synchronous read port, at whatever rate it likes. This decouples the radio sample rate from the classifier's compute rate.

Capture is driven by three single-cycle control strobes from a register block:
- **start** enables capture.
- **stop** ends capture at the next frame boundary.
- **clear** immediately abandons the current frame.

A counter records every valid beat that arrives while the block cannot take it.

Top module: `iq_frame_capture`

## Requirements
- R1: A stored word is split with the in-phase value in bits [15:0] and the quadrature value in bits [31:16]. The in-phase value goes to plane 0 and the quadrature value to plane 1, both at the same address.
- R2: Samples are stored in row-major order, at address row*32+col, starting from address 0. The write address advances only on a beat where s_tvalid and s_tready are both high. frame_ready rises in the cycle after the 1024th accepted beat and not earlier.
- R3: Once raised, frame_ready stays high until a cycle with frame_ack high. After that acknowledge, frame_ready is low, and capture continues into a new frame from address 0 unless a stop is pending.
- R4: s_tready is low while frame_ready is high and while capture is stopped. Capture is stopped after rst. A beat offered while s_tready is low leaves the stored frame unchanged.
- R5: The read port returns plane rd_plane (0 = in-phase, 1 = quadrature) at address rd_addr on rd_data one cycle after the address is presented, independently of capture activity.
- R6: A ctl_start strobe while stopped makes s_tready high in the next cycle. ctl_start also cancels a pending stop.
- R7: A ctl_stop strobe in the middle of a frame lets that frame complete. After its acknowledge, capture stays stopped. A ctl_stop strobe while running at address 0 makes s_tready low from the next cycle on.
- R8: A ctl_clear strobe takes priority over every other input. In the next cycle it leaves frame_ready low, s_tready low, the write address at 0 and ovf_count at 0.
- R9: ovf_count increases by exactly one for each cycle in which s_tvalid is high and s_tready is low. It saturates at its maximum value and is otherwise unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_tdata | input | 32 | Stream word: quadrature in [31:16], in-phase in [15:0] |
| s_tvalid | input | 1 | Stream beat valid |
| s_tready | output | 1 | Block can accept a beat |
| ctl_start | input | 1 | Strobe: enable capture |
| ctl_stop | input | 1 | Strobe: stop at the next frame boundary |
| ctl_clear | input | 1 | Strobe: abandon the frame, clear the pointer, flag and counter |
| frame_ready | output | 1 | A complete frame is held in the planes |
| frame_ack | input | 1 | Consumer has finished with the frame |
| rd_addr | input | 10 | Read address, row*32+col |
| rd_plane | input | 1 | Read plane select, 0 in-phase, 1 quadrature |
| rd_data | output | 16 | Read data, one cycle after the address |
| ovf_count | output | 16 | Count of beats refused while not ready |

## Verification
The assertions assume that the control strobes and frame_ack are synchronous to clk. They also assume that frame_ack is meaningful only while frame_ready is high, and that nothing but ctl_clear is expected to change the counter during a clear. The stimulus drives every input away from the active edge. It pulses each strobe for exactly one cycle, and it asserts frame_ack only after frame_ready has been seen high. Valid beats with random gaps are offered while the block is running, full, stopped and just after a clear, so that the refused-beat path is exercised in each state.

// File: rtl/iq_cap_pkg.sv
package iq_cap_pkg;

    localparam int COMP_W   = 16;
    localparam int WORD_W   = 2 * COMP_W;
    localparam int N_PLANES = 2;

    typedef struct packed {
        logic [COMP_W-1:0] q;
        logic [COMP_W-1:0] i;
    } iq_word_t;

    typedef enum logic [1:0] {
        CAP_IDLE = 2'd0,
        CAP_RUN  = 2'd1,
        CAP_FULL = 2'd2
    } cap_state_e;

    // Plane 0 holds in-phase values, plane 1 quadrature values.
    function automatic logic [COMP_W-1:0] plane_part(input iq_word_t w, input int unsigned p);
        return (p == 0) ? w.i : w.q;
    endfunction

endpackage

// File: rtl/iq_plane_ram.sv
module iq_plane_ram #(
    parameter int DW    = 16,
    parameter int DEPTH = 1024,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/iq_cap_ctrl.sv
module iq_cap_ctrl
    import iq_cap_pkg::*;
#(
    parameter int FRAME = 1024,
    parameter int AW    = $clog2(FRAME)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          stop,
    input  logic          clear,
    input  logic          valid,
    input  logic          ack,
    output logic          ready,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic          frame_ready
);

    localparam logic [AW-1:0] LAST = AW'(FRAME - 1);

    cap_state_e    state;
    logic [AW-1:0] ptr;
    logic          stop_pend;

    assign ready   = (state == CAP_RUN) && !(stop_pend && (ptr == '0));
    assign wr_en   = valid && ready;
    assign wr_addr = ptr;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            state       <= CAP_IDLE;
            ptr         <= '0;
            stop_pend   <= 1'b0;
            frame_ready <= 1'b0;
        end else begin
            unique case (state)
                CAP_IDLE: begin
                    if (start) begin
                        state     <= CAP_RUN;
                        stop_pend <= 1'b0;
                    end
                end
                CAP_RUN: begin
                    if (wr_en) begin
                        if (ptr == LAST) begin
                            ptr         <= '0;
                            state       <= CAP_FULL;
                            frame_ready <= 1'b1;
                        end else begin
                            ptr <= ptr + 1'b1;
                        end
                    end else if (stop_pend && (ptr == '0) && !start) begin
                        state <= CAP_IDLE;
                    end
                    if (start) begin
                        stop_pend <= 1'b0;
                    end else if (stop) begin
                        stop_pend <= 1'b1;
                    end else if (stop_pend && (ptr == '0) && !wr_en) begin
                        stop_pend <= 1'b0;
                    end
                end
                CAP_FULL: begin
                    if (ack) begin
                        frame_ready <= 1'b0;
                        if ((stop_pend || stop) && !start) begin
                            state <= CAP_IDLE;
                        end else begin
                            state <= CAP_RUN;
                        end
                        stop_pend <= 1'b0;
                    end else if (start) begin
                        stop_pend <= 1'b0;
                    end else if (stop) begin
                        stop_pend <= 1'b1;
                    end
                end
                default: state <= CAP_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/iq_ovf_counter.sv
module iq_ovf_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         hit,
    output logic [W-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count <= '0;
        end else if (hit && (count != '1)) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/iq_frame_capture.sv
module iq_frame_capture
    import iq_cap_pkg::*;
#(
    parameter int ROWS  = 32,
    parameter int COLS  = 32,
    parameter int OVF_W = 16,
    localparam int FRAME = ROWS * COLS,
    localparam int AW    = $clog2(FRAME)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] s_tdata,
    input  logic              s_tvalid,
    output logic              s_tready,
    input  logic              ctl_start,
    input  logic              ctl_stop,
    input  logic              ctl_clear,
    output logic              frame_ready,
    input  logic              frame_ack,
    input  logic [AW-1:0]     rd_addr,
    input  logic              rd_plane,
    output logic [COMP_W-1:0] rd_data,
    output logic [OVF_W-1:0]  ovf_count
);

    iq_word_t          word;
    logic              wr_en;
    logic [AW-1:0]     wr_addr;
    logic [COMP_W-1:0] plane_rd [N_PLANES];
    logic              rd_sel_q;

    assign word = iq_word_t'(s_tdata);

    iq_cap_ctrl #(.FRAME(FRAME), .AW(AW)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start       (ctl_start),
        .stop        (ctl_stop),
        .clear       (ctl_clear),
        .valid       (s_tvalid),
        .ack         (frame_ack),
        .ready       (s_tready),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .frame_ready (frame_ready)
    );

    for (genvar p = 0; p < N_PLANES; p++) begin : g_plane
        iq_plane_ram #(.DW(COMP_W), .DEPTH(FRAME), .AW(AW)) u_ram (
            .clk   (clk),
            .we    (wr_en),
            .waddr (wr_addr),
            .wdata (plane_part(word, p)),
            .raddr (rd_addr),
            .rdata (plane_rd[p])
        );
    end

    always_ff @(posedge clk) begin
        rd_sel_q <= rd_plane;
    end

    assign rd_data = plane_rd[rd_sel_q];

    iq_ovf_counter #(.W(OVF_W)) u_ovf (
        .clk   (clk),
        .rst   (rst),
        .clear (ctl_clear),
        .hit   (s_tvalid && !s_tready),
        .count (ovf_count)
    );

endmodule

// File: rtl/iq_frame_capture_chk.sv
module iq_frame_capture_chk #(
    parameter int OVF_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             s_tvalid,
    input logic             s_tready,
    input logic             ctl_start,
    input logic             ctl_stop,
    input logic             ctl_clear,
    input logic             frame_ready,
    input logic             frame_ack,
    input logic [OVF_W-1:0] ovf_count
);

    p_full_blocks_r4: assert property (@(posedge clk) disable iff (rst)
        frame_ready |-> !s_tready);

    p_ready_held_r3: assert property (@(posedge clk) disable iff (rst)
        (frame_ready && !frame_ack && !ctl_clear) |=> frame_ready);

    p_ready_after_beat_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_ready) |-> $past(s_tvalid && s_tready));

    p_start_opens_r6: assert property (@(posedge clk) disable iff (rst)
        (ctl_start && !ctl_stop && !ctl_clear && !frame_ready && !(s_tvalid && s_tready))
        |=> s_tready);

    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
        ctl_clear |=> (!frame_ready && !s_tready && (ovf_count == '0)));

    p_ovf_step_r9: assert property (@(posedge clk) disable iff (rst)
        (s_tvalid && !s_tready && !ctl_clear && (ovf_count != '1))
        |=> (ovf_count == $past(ovf_count) + 1'b1));

    p_ovf_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!(s_tvalid && !s_tready) && !ctl_clear) |=> $stable(ovf_count));

endmodule

bind iq_frame_capture iq_frame_capture_chk #(.OVF_W(OVF_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .s_tvalid    (s_tvalid),
    .s_tready    (s_tready),
    .ctl_start   (ctl_start),
    .ctl_stop    (ctl_stop),
    .ctl_clear   (ctl_clear),
    .frame_ready (frame_ready),
    .frame_ack   (frame_ack),
    .ovf_count   (ovf_count)
);

// File: tb/sim_iq_frame_capture.sv
module sim_iq_frame_capture;

    localparam int CLK_P = 10;
    localparam int FRAME = 1024;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] s_tdata;
    logic        s_tvalid;
    logic        s_tready;
    logic        ctl_start, ctl_stop, ctl_clear;
    logic        frame_ready;
    logic        frame_ack;
    logic [9:0]  rd_addr;
    logic        rd_plane;
    logic [15:0] rd_data;
    logic [15:0] ovf_count;

    int          n_chk  = 0;
    int          n_fail = 0;
    int          ovf_exp = 0;
    bit          done = 0;
    logic [15:0] exp_i [FRAME];
    logic [15:0] exp_q [FRAME];

    always #(CLK_P/2) clk = ~clk;

    iq_frame_capture u0 (
        .clk(clk), .rst(rst), .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tready(s_tready),
        .ctl_start(ctl_start), .ctl_stop(ctl_stop), .ctl_clear(ctl_clear),
        .frame_ready(frame_ready), .frame_ack(frame_ack),
        .rd_addr(rd_addr), .rd_plane(rd_plane), .rd_data(rd_data), .ovf_count(ovf_count)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pattern(input int mode, input int k);
        logic [15:0] kk = 16'(k);
        case (mode)
            1:       return {~kk, kk};
            2:       return {kk + 16'h0100, kk ^ 16'hA5A5};
            default: return {16'h7000 - kk, 16'h3000 + kk};
        endcase
    endfunction

    // Offer one beat; took reports whether it was accepted.
    task automatic beat(input logic [31:0] w, output bit took);
        @(negedge clk);
        s_tvalid = 1'b1;
        s_tdata  = w;
        took     = s_tready;
        if (!took) ovf_exp++;
        @(posedge clk);
        #1 s_tvalid = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); ctl_start = 1'b1; @(posedge clk); #1 ctl_start = 1'b0;
    endtask
    task automatic pulse_stop();
        @(negedge clk); ctl_stop = 1'b1; @(posedge clk); #1 ctl_stop = 1'b0;
    endtask
    task automatic pulse_clear();
        @(negedge clk); ctl_clear = 1'b1; @(posedge clk); #1 ctl_clear = 1'b0;
    endtask
    task automatic pulse_ack();
        @(negedge clk); frame_ack = 1'b1; @(posedge clk); #1 frame_ack = 1'b0;
    endtask

    // Fill addresses [from, upto); mode 0 uses random words.
    task automatic fill(input int mode, input int from, input int upto);
        int k = from;
        while (k < upto) begin
            bit took;
            logic [31:0] w;
            for (int g = 0; g < int'($urandom_range(2)); g++) @(negedge clk);
            w = (mode == 0) ? $urandom : pattern(mode, k);
            beat(w, took);
            if (took) begin
                exp_i[k] = w[15:0];
                exp_q[k] = w[31:16];
                k++;
                if (k == FRAME - 1) check("R2 not ready before last beat", 32'(frame_ready), 0);
                if (k == FRAME)     check("R2 ready after last beat", 32'(frame_ready), 1);
            end
        end
    endtask

    task automatic read_chk(input int a, input bit p, input string req);
        @(negedge clk);
        rd_addr  = 10'(a);
        rd_plane = p;
        @(negedge clk);
        check(req, 32'(rd_data), 32'(p ? exp_q[a] : exp_i[a]));
    endtask

    task automatic read_set(input string req);
        read_chk(0, 0, req);    read_chk(0, 1, req);
        read_chk(31, 0, req);   read_chk(32, 1, req);
        read_chk(1023, 0, req); read_chk(1023, 1, req);
        for (int j = 0; j < 6; j++) read_chk(int'($urandom_range(1023)), j[0], req);
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        bit took;
        void'($urandom(32'd2024));
        rst = 1'b1; s_tdata = '0; s_tvalid = 0; ctl_start = 0; ctl_stop = 0;
        ctl_clear = 0; frame_ack = 0; rd_addr = '0; rd_plane = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        check("R4 reset tready", 32'(s_tready), 0);
        check("R3 reset frame_ready", 32'(frame_ready), 0);
        check("R9 reset ovf", 32'(ovf_count), 0);

        // R4/R9: beat while stopped is refused and counted
        beat(32'h1, took);
        check("R4 refused while stopped", 32'(took), 0);
        @(negedge clk);
        check("R9 count after refused beat", 32'(ovf_count), 32'(ovf_exp));

        // R6: start opens the stream
        pulse_start();
        @(negedge clk);
        check("R6 tready after start", 32'(s_tready), 1);

        // R1/R2: random frame
        fill(0, 0, FRAME);
        @(negedge clk);
        check("R4 tready low when full", 32'(s_tready), 0);
        repeat (20) @(negedge clk);
        check("R3 frame_ready held", 32'(frame_ready), 1);
        for (int j = 0; j < 5; j++) beat(32'hDEAD_BEEF, took);
        @(negedge clk);
        check("R9 count while full", 32'(ovf_count), 32'(ovf_exp));
        read_set("R1 R5 frame one readback");

        // R3: acknowledge resumes capture
        pulse_ack();
        @(negedge clk);
        check("R3 frame_ready after ack", 32'(frame_ready), 0);
        check("R3 tready after ack", 32'(s_tready), 1);

        // R7: stop mid-frame lets the frame finish
        fill(1, 0, 500);
        pulse_stop();
        @(negedge clk);
        check("R7 tready kept mid-frame", 32'(s_tready), 1);
        fill(1, 500, FRAME);
        pulse_ack();
        @(negedge clk);
        check("R7 frame_ready after ack", 32'(frame_ready), 0);
        repeat (5) @(negedge clk);
        check("R7 stopped after ack", 32'(s_tready), 0);
        read_set("R1 R5 frame two readback");

        // R4: beats while stopped leave the frame untouched
        for (int j = 0; j < 3; j++) beat(32'hFFFF_FFFF, took);
        @(negedge clk);
        check("R9 count while stopped", 32'(ovf_count), 32'(ovf_exp));
        read_chk(0, 0, "R4 frame unchanged I");
        read_chk(0, 1, "R4 frame unchanged Q");

        // R7: stop at address 0 closes the stream next cycle
        pulse_start();
        @(negedge clk);
        check("R6 tready after restart", 32'(s_tready), 1);
        pulse_stop();
        @(negedge clk);
        check("R7 stop at boundary", 32'(s_tready), 0);

        // R8: clear abandons a partial frame
        pulse_start();
        fill(2, 0, 10);
        beat(32'h0, took);
        if (took) begin
            exp_i[10] = 16'h0; exp_q[10] = 16'h0;
        end
        pulse_clear();
        ovf_exp = 0;
        @(negedge clk);
        check("R8 tready after clear", 32'(s_tready), 0);
        check("R8 frame_ready after clear", 32'(frame_ready), 0);
        check("R8 ovf after clear", 32'(ovf_count), 0);
        pulse_start();
        fill(3, 0, FRAME);
        read_set("R8 pointer restarted at zero");
        pulse_ack();

        done = 1;
        finish_run();
    end

endmodule